// File: doc/BRIEF.md
# Output Driver Strength Calibration Controller

This block sits on the device side of a memory interface and runs the trimming of the output driver. An extended-mode write that the command decoder has already recognised arrives with a 3-bit operation code. The codes let the controller force the data pins to a fixed level so the controller on the other end can measure them, enter an adjust mode, leave calibration, or reload the default strength.

In adjust mode the host sends a write, and a 4-beat serial code then arrives on the data pin. Each beat carries one bit of the code. The code moves the pull-up and the pull-down strength codes one step up or down, each on its own. Both strength codes are kept as saturating counters that feed the analog driver. After every adjustment code the host has to send an exit command before it may issue any other mode command. An adjustment code that is not defined changes nothing and sets a sticky error flag.

Top module: `ocd_cal_ctrl`

## Requirements
- R1: After reset, both strength codes are 8 (mid-scale), no level is forced, adjust mode is off, the error flag is 0 and no exit is pending.
- R2: Operation code 001 forces the data pin high, the true strobe high and the complementary strobe low. Operation code 010 forces the data pin low, the true strobe low and the complementary strobe high. Both take effect on the clock edge that samples the command.
- R3: Operation code 000 returns to idle, releases any forced level and clears a pending exit.
- R4: Operation code 100 enters adjust mode on the sampling edge.
- R5: In adjust mode, the beat carrying DT(k), for k = 0..3, is sampled on edge WL+1+k after the edge that sampled the write command. The strength codes change on the edge after the last beat and not earlier.
- R6: The code is written DT0 DT1 DT2 DT3. Code 0000 changes nothing. 0001 raises the pull-up, 0010 lowers the pull-up, 0100 raises the pull-down and 1000 lowers the pull-down, each by one step.
- R7: 0101 raises both. 0110 lowers the pull-up and raises the pull-down. 1001 raises the pull-up and lowers the pull-down. 1010 lowers both.
- R8: The strength codes saturate at 15 and at 0 and never wrap.
- R9: A code that sets both raise and lower for the same driver (DT2 with DT3, or DT0 with DT1) is reserved. It leaves both strength codes unchanged and sets the error flag, which stays set until reset.
- R10: After an adjustment code is taken, an exit is pending. Until operation code 000 arrives, every other operation code and any further write burst is ignored.
- R11: Operation code 111 reloads both strength codes to 8 and returns to idle only when both impedance-select bits are 1. Otherwise it is ignored.
- R12: Operation codes 011, 101 and 110 are ignored. A write outside adjust mode starts no capture. A mode command that arrives while a burst is being captured is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| emr_wr | input | 1 | Decoded extended-mode write strobe |
| emr_op | input | 3 | Calibration operation code carried by the mode write |
| imp_sel | input | 2 | Driver impedance select bits; 2'b11 is full strength |
| wr_cmd | input | 1 | Write command strobe that starts an adjustment burst |
| dq_bit | input | 1 | Serial adjustment code bit from the data pin |
| pu_code | output | CODE_W | Pull-up strength code |
| pd_code | output | CODE_W | Pull-down strength code |
| adj_mode | output | 1 | Adjust mode active |
| force_en | output | 1 | Drive-test mode active; pins are forced |
| force_dq | output | 1 | Forced data pin level |
| force_dqs | output | 1 | Forced true strobe level |
| force_dqs_n | output | 1 | Forced complementary strobe level |
| exit_pending | output | 1 | An adjustment was taken and an exit is required |
| cal_err | output | 1 | Sticky flag for a reserved adjustment code |

## Verification
Every single-driver code and every combined code is sent, and the resulting pair of strength codes shows whether the bits were decoded with the correct beat order and polarity. The data pin is held at 1 outside the beat window, so a capture that opens one cycle early or late produces a different code. Repeated raises and lowers run both counters into their limits, which exposes wrap-around. Reserved codes, commands sent while an exit is pending, commands sent during capture, and the default reload with a non-full impedance setting each show whether a command that must be ignored left both the pin state and the strength codes alone.

// File: rtl/ocd_cal_pkg.sv
package ocd_cal_pkg;

  typedef enum logic [1:0] {
    CM_IDLE   = 2'd0,
    CM_DRV_HI = 2'd1,
    CM_DRV_LO = 2'd2,
    CM_ADJUST = 2'd3
  } cal_mode_e;

  localparam logic [2:0] OP_EXIT = 3'b000;
  localparam logic [2:0] OP_DRV1 = 3'b001;
  localparam logic [2:0] OP_DRV0 = 3'b010;
  localparam logic [2:0] OP_ADJ  = 3'b100;
  localparam logic [2:0] OP_DFLT = 3'b111;

  // beat k of the burst lands in bit k: DT3 raises pull-up, DT2 lowers it,
  // DT1 raises pull-down, DT0 lowers it
  typedef struct packed {
    logic pu_up;
    logic pu_dn;
    logic pd_up;
    logic pd_dn;
  } adj_req_t;

  function automatic adj_req_t decode_beats(input logic [3:0] beats);
    return adj_req_t'(beats);
  endfunction

  function automatic logic is_reserved(input adj_req_t r);
    return (r.pu_up & r.pu_dn) | (r.pd_up & r.pd_dn);
  endfunction

  function automatic logic [7:0] sat_step(input logic [7:0] cur,
                                          input logic [7:0] lim,
                                          input logic up,
                                          input logic dn);
    if (up && !dn && cur != lim) return cur + 8'd1;
    if (dn && !up && cur != 8'd0) return cur - 8'd1;
    return cur;
  endfunction

endpackage

// File: rtl/ocd_mode_fsm.sv
module ocd_mode_fsm
  import ocd_cal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      emr_wr,
  input  logic [2:0] emr_op,
  input  logic      imp_full,
  input  logic      cap_busy,
  input  logic      code_vld,
  output cal_mode_e mode,
  output logic      exit_pending,
  output logic      dflt_load
);

  logic cmd_ok;
  logic cmd_free;

  assign cmd_ok   = emr_wr && !cap_busy && !code_vld;
  assign cmd_free = cmd_ok && !exit_pending;
  assign dflt_load = cmd_free && (emr_op == OP_DFLT) && imp_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode         <= CM_IDLE;
      exit_pending <= 1'b0;
    end else if (code_vld) begin
      exit_pending <= 1'b1;
    end else if (cmd_ok && emr_op == OP_EXIT) begin
      mode         <= CM_IDLE;
      exit_pending <= 1'b0;
    end else if (cmd_free) begin
      case (emr_op)
        OP_DRV1: mode <= CM_DRV_HI;
        OP_DRV0: mode <= CM_DRV_LO;
        OP_ADJ:  mode <= CM_ADJUST;
        OP_DFLT: if (imp_full) mode <= CM_IDLE;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ocd_burst_capture.sv
module ocd_burst_capture #(
  parameter int WL    = 4,
  parameter int BEATS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dq_bit,
  output logic             busy,
  output logic             code_vld,
  output logic [BEATS-1:0] beats
);

  localparam int FIRST = WL + 1;
  localparam int LAST  = WL + BEATS;
  localparam int CNT_W = $clog2(LAST + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      code_vld <= 1'b0;
      cnt      <= '0;
      beats    <= '0;
    end else begin
      code_vld <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        cnt   <= CNT_W'(1);
        beats <= '0;
      end else if (busy) begin
        for (int b = 0; b < BEATS; b++) begin
          if (cnt == CNT_W'(FIRST + b)) beats[b] <= dq_bit;
        end
        if (cnt == CNT_W'(LAST)) begin
          busy     <= 1'b0;
          code_vld <= 1'b1;
        end
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/ocd_step_cnt.sv
module ocd_step_cnt
  import ocd_cal_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              up,
  input  logic              dn,
  input  logic              load_mid,
  output logic [CODE_W-1:0] code
);

  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= MID;
    end else if (load_mid) begin
      code <= MID;
    end else if (step_en) begin
      code <= CODE_W'(sat_step(8'(code), 8'(MAX), up, dn));
    end
  end

endmodule

// File: rtl/ocd_cal_ctrl.sv
module ocd_cal_ctrl
  import ocd_cal_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int WL     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emr_wr,
  input  logic [2:0]        emr_op,
  input  logic [1:0]        imp_sel,
  input  logic              wr_cmd,
  input  logic              dq_bit,
  output logic [CODE_W-1:0] pu_code,
  output logic [CODE_W-1:0] pd_code,
  output logic              adj_mode,
  output logic              force_en,
  output logic              force_dq,
  output logic              force_dqs,
  output logic              force_dqs_n,
  output logic              exit_pending,
  output logic              cal_err
);

  localparam int BEATS = 4;
  localparam int NDRV  = 2;

  cal_mode_e        mode;
  logic             imp_full;
  logic             cap_busy;
  logic             code_vld;
  logic [BEATS-1:0] beats;
  logic             cap_start;
  logic             dflt_load;
  logic             bad_code;
  logic             step_ok;
  adj_req_t         req;
  logic [NDRV-1:0]  drv_up;
  logic [NDRV-1:0]  drv_dn;
  logic [CODE_W-1:0] drv_code [NDRV];

  assign imp_full  = &imp_sel;
  assign cap_start = wr_cmd && (mode == CM_ADJUST) && !exit_pending
                     && !cap_busy && !code_vld;

  ocd_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .emr_wr       (emr_wr),
    .emr_op       (emr_op),
    .imp_full     (imp_full),
    .cap_busy     (cap_busy),
    .code_vld     (code_vld),
    .mode         (mode),
    .exit_pending (exit_pending),
    .dflt_load    (dflt_load)
  );

  ocd_burst_capture #(.WL(WL), .BEATS(BEATS)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cap_start),
    .dq_bit   (dq_bit),
    .busy     (cap_busy),
    .code_vld (code_vld),
    .beats    (beats)
  );

  assign req      = decode_beats(beats);
  assign bad_code = is_reserved(req);
  assign step_ok  = code_vld && !bad_code;

  // index 0 is the pull-up leg, index 1 the pull-down leg
  assign drv_up = {req.pd_up, req.pu_up};
  assign drv_dn = {req.pd_dn, req.pu_dn};

  for (genvar d = 0; d < NDRV; d++) begin : g_leg
    ocd_step_cnt #(.CODE_W(CODE_W)) u_leg (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_en  (step_ok),
      .up       (drv_up[d]),
      .dn       (drv_dn[d]),
      .load_mid (dflt_load),
      .code     (drv_code[d])
    );
  end

  assign pu_code = drv_code[0];
  assign pd_code = drv_code[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cal_err <= 1'b0;
    else if (code_vld && bad_code) cal_err <= 1'b1;
  end

  assign adj_mode    = (mode == CM_ADJUST);
  assign force_en    = (mode == CM_DRV_HI) || (mode == CM_DRV_LO);
  assign force_dq    = (mode == CM_DRV_HI);
  assign force_dqs   = (mode == CM_DRV_HI);
  assign force_dqs_n = (mode == CM_DRV_LO);

endmodule

// File: rtl/ocd_cal_chk.sv
module ocd_cal_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              emr_wr,
  input logic [2:0]        emr_op,
  input logic              wr_cmd,
  input logic              code_vld,
  input logic              bad_code,
  input logic              dflt_load,
  input logic              cap_busy,
  input logic [CODE_W-1:0] pu_code,
  input logic [CODE_W-1:0] pd_code,
  input logic              adj_mode,
  input logic              force_en,
  input logic              exit_pending,
  input logic              cal_err
);

  // R6: a strength code moves only after a taken code or a default reload
  p_pu_moves_on_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pu_code) |-> ($past(code_vld) || $past(dflt_load)));
  p_pd_moves_on_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pd_code) |-> ($past(code_vld) || $past(dflt_load)));

  // R8: no wrap at either end
  p_pu_no_wrap_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (code_vld && pu_code == '1) |=> pu_code != '0);
  p_pu_no_wrap_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (code_vld && pu_code == '0) |=> pu_code != '1);
  p_pd_no_wrap_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (code_vld && pd_code == '1) |=> pd_code != '0);
  p_pd_no_wrap_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (code_vld && pd_code == '0) |=> pd_code != '1);

  // R9: reserved code holds both legs and raises the flag, which sticks
  p_reserved_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (code_vld && bad_code) |=> ($stable(pu_code) && $stable(pd_code) && cal_err));
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cal_err |=> cal_err);

  // R10: while an exit is owed, other commands change nothing
  p_exit_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_pending && emr_wr && emr_op != 3'b000)
      |=> ($stable(force_en) && $stable(adj_mode) && exit_pending));

  // R5: a completed burst belongs to adjust mode
  p_code_in_adjust_r5: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld |-> adj_mode);

  // R12: writes outside adjust mode start no capture
  p_no_cap_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !adj_mode && !cap_busy) |=> !cap_busy);

endmodule

bind ocd_cal_ctrl ocd_cal_chk #(.CODE_W(CODE_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .emr_wr       (emr_wr),
  .emr_op       (emr_op),
  .wr_cmd       (wr_cmd),
  .code_vld     (code_vld),
  .bad_code     (bad_code),
  .dflt_load    (dflt_load),
  .cap_busy     (cap_busy),
  .pu_code      (pu_code),
  .pd_code      (pd_code),
  .adj_mode     (adj_mode),
  .force_en     (force_en),
  .exit_pending (exit_pending),
  .cal_err      (cal_err)
);

// File: tb/test_ocd_cal_ctrl.sv
module test_ocd_cal_ctrl;

  localparam int CODE_W = 4;
  localparam int WL     = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic emr_wr = 1'b0;
  logic [2:0] emr_op = 3'b000;
  logic [1:0] imp_sel = 2'b00;
  logic wr_cmd = 1'b0;
  logic dq_bit = 1'b1;
  logic [CODE_W-1:0] pu_code, pd_code;
  logic adj_mode, force_en, force_dq, force_dqs, force_dqs_n, exit_pending, cal_err;

  int n_run = 0;
  int n_fail = 0;
  int m_pu = 8;
  int m_pd = 8;
  int m_err = 0;
  bit reported = 1'b0;

  always #4 clk = ~clk;

  ocd_cal_ctrl #(.CODE_W(CODE_W), .WL(WL)) i_ocd_cal_ctrl (
    .clk(clk), .rst_n(rst_n), .emr_wr(emr_wr), .emr_op(emr_op),
    .imp_sel(imp_sel), .wr_cmd(wr_cmd), .dq_bit(dq_bit),
    .pu_code(pu_code), .pd_code(pd_code), .adj_mode(adj_mode),
    .force_en(force_en), .force_dq(force_dq), .force_dqs(force_dqs),
    .force_dqs_n(force_dqs_n), .exit_pending(exit_pending), .cal_err(cal_err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // reference: apply a code written DT0..DT3 left to right
  task automatic model_code(input logic [3:0] s);
    int dpu = 0;
    int dpd = 0;
    case (s)
      4'b0000: ;
      4'b0001: dpu = 1;
      4'b0010: dpu = -1;
      4'b0100: dpd = 1;
      4'b1000: dpd = -1;
      4'b0101: begin dpu = 1;  dpd = 1;  end
      4'b0110: begin dpu = -1; dpd = 1;  end
      4'b1001: begin dpu = 1;  dpd = -1; end
      4'b1010: begin dpu = -1; dpd = -1; end
      default: m_err = 1;
    endcase
    m_pu = (m_pu + dpu > 15) ? 15 : ((m_pu + dpu < 0) ? 0 : m_pu + dpu);
    m_pd = (m_pd + dpd > 15) ? 15 : ((m_pd + dpd < 0) ? 0 : m_pd + dpd);
  endtask

  task automatic emr(input logic [2:0] op);
    @(negedge clk); emr_wr = 1'b1; emr_op = op;
    @(negedge clk); emr_wr = 1'b0; emr_op = 3'b000;
  endtask

  // ends after the update edge (WL+5)
  task automatic burst(input logic [3:0] s, input bit inject, input bit lat_chk);
    @(negedge clk); wr_cmd = 1'b1;
    @(negedge clk); wr_cmd = 1'b0;
    for (int c = 1; c <= WL; c++) begin
      if (inject && c == 2) begin emr_wr = 1'b1; emr_op = 3'b001; end
      @(negedge clk);
      emr_wr = 1'b0; emr_op = 3'b000;
    end
    for (int k = 0; k < 4; k++) begin
      dq_bit = s[3-k];
      @(negedge clk);
    end
    dq_bit = 1'b1;
    if (lat_chk) begin
      check("R5 pu before update", int'(pu_code), m_pu);
      check("R5 pd before update", int'(pd_code), m_pd);
    end
    @(negedge clk);
  endtask

  task automatic adj_step(input logic [3:0] s, input bit lat_chk);
    emr(3'b100);
    burst(s, 1'b0, lat_chk);
    model_code(s);
    emr(3'b000);
  endtask

  task automatic expect_codes(input string req);
    check({req, " pu"}, int'(pu_code), m_pu);
    check({req, " pd"}, int'(pd_code), m_pd);
  endtask

  task automatic t_reset();
    check("R1 pu", int'(pu_code), 8);
    check("R1 pd", int'(pd_code), 8);
    check("R1 force", int'(force_en), 0);
    check("R1 adj", int'(adj_mode), 0);
    check("R1 err", int'(cal_err), 0);
    check("R1 exit", int'(exit_pending), 0);
  endtask

  task automatic t_drive();
    emr(3'b001);
    check("R2 hi force", int'(force_en), 1);
    check("R2 hi dq", int'(force_dq), 1);
    check("R2 hi dqs", int'(force_dqs), 1);
    check("R2 hi dqs_n", int'(force_dqs_n), 0);
    emr(3'b011);
    check("R12 reserved op keeps dq", int'(force_dq), 1);
    emr(3'b010);
    check("R2 lo force", int'(force_en), 1);
    check("R2 lo dq", int'(force_dq), 0);
    check("R2 lo dqs", int'(force_dqs), 0);
    check("R2 lo dqs_n", int'(force_dqs_n), 1);
    emr(3'b000);
    check("R3 exit releases", int'(force_en), 0);
  endtask

  task automatic t_single();
    emr(3'b100);
    check("R4 adjust on", int'(adj_mode), 1);
    burst(4'b0001, 1'b0, 1'b1);
    model_code(4'b0001);
    expect_codes("R5 R6 0001");
    check("R10 exit owed", int'(exit_pending), 1);
    emr(3'b000);
    check("R3 exit clears pending", int'(exit_pending), 0);
    check("R3 exit leaves adjust", int'(adj_mode), 0);
    adj_step(4'b0010, 1'b1); expect_codes("R6 0010");
    adj_step(4'b0100, 1'b1); expect_codes("R6 0100");
    adj_step(4'b1000, 1'b1); expect_codes("R6 1000");
    adj_step(4'b0000, 1'b0); expect_codes("R6 0000");
  endtask

  task automatic t_combined();
    adj_step(4'b0101, 1'b1); expect_codes("R7 0101");
    adj_step(4'b0110, 1'b0); expect_codes("R7 0110");
    adj_step(4'b1001, 1'b0); expect_codes("R7 1001");
    adj_step(4'b1010, 1'b0); expect_codes("R7 1010");
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 10; i++) adj_step(4'b0001, 1'b0);
    check("R8 pu at top", int'(pu_code), 15);
    for (int i = 0; i < 10; i++) adj_step(4'b1000, 1'b0);
    check("R8 pd at bottom", int'(pd_code), 0);
    adj_step(4'b1001, 1'b0);
    expect_codes("R8 both at limits");
    adj_step(4'b0010, 1'b0);
    check("R8 pu steps down", int'(pu_code), 14);
  endtask

  task automatic t_reserved();
    adj_step(4'b0011, 1'b0);
    expect_codes("R9 reserved holds");
    check("R9 err set", int'(cal_err), 1);
    adj_step(4'b0100, 1'b0);
    expect_codes("R9 valid after reserved");
    check("R9 err sticky", int'(cal_err), m_err);
  endtask

  task automatic t_exit_rule();
    emr(3'b100);
    burst(4'b0001, 1'b0, 1'b0);
    model_code(4'b0001);
    emr(3'b001);
    check("R10 drive blocked", int'(force_en), 0);
    check("R10 still adjust", int'(adj_mode), 1);
    burst(4'b0001, 1'b0, 1'b0);
    expect_codes("R10 second burst ignored");
    emr(3'b000);
    check("R10 exit accepted", int'(exit_pending), 0);
  endtask

  task automatic t_ignored();
    burst(4'b0001, 1'b0, 1'b0);
    expect_codes("R12 idle write ignored");
    check("R12 idle no pending", int'(exit_pending), 0);
    emr(3'b100);
    burst(4'b0001, 1'b1, 1'b0);
    model_code(4'b0001);
    check("R12 mode cmd during capture", int'(force_en), 0);
    expect_codes("R12 capture completes");
    emr(3'b000);
  endtask

  task automatic t_default();
    imp_sel = 2'b01;
    emr(3'b111);
    expect_codes("R11 not full strength");
    imp_sel = 2'b11;
    emr(3'b001);
    emr(3'b111);
    m_pu = 8; m_pd = 8;
    expect_codes("R11 reload");
    check("R11 back to idle", int'(force_en), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_drive();
    t_single();
    t_combined();
    t_saturate();
    t_reserved();
    t_exit_rule();
    t_ignored();
    t_default();
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule